// File: doc/BRIEF.md
# CAN receive buffer allocator

This block sits between the frame receiver of a CAN controller and a bank of message buffers. When the receiver reaches the point in the end-of-frame field where the incoming frame is considered error free, it raises a decision strobe. At that moment every buffer's acceptance filter is evaluated in parallel on the received identifier, and the result is masked with the buffer enable vector. A fixed number of clock cycles later the frame is written into the lowest-indexed surviving candidate. On that write the buffer's flags are updated and the last-event pointer is loaded. An error reported in the window between decision and store cancels the frame.

Each buffer holds an identifier and a mask select. The select chooses one of three filters: an exact compare, or a compare through one of two shared mask registers, in which a mask bit of 1 makes that identifier bit a don't-care. Identifiers and masks change only while the controller is halted. The enable vector is captured once, at the decision strobe, and only that copy steers the store. A buffer cleared between decision and store therefore still takes the frame it was chosen for, and a frame is never redirected to a default buffer.

The control is a three-state machine. IDLE waits for the decision strobe, captures the candidate vector and the frame, and moves to WAIT. WAIT counts the store delay and returns to IDLE on an error (abort) or moves to STORE when the count expires. STORE performs the write, or discards the frame when no candidate exists, and returns to IDLE.

Top module: `can_rx_alloc`

## Requirements
- R1: After reset all receive, overrun and remote flags are 0 and the last-event pointer is 0.
- R2: A buffer's filter passes when ((rx_id XOR buffer id) AND NOT mask) is zero. The mask is 0 for select 0 (exact), the first shared mask for select 1 and the second for select 2. Select 3 acts as exact.
- R3: When several enabled buffers pass their filters, the frame goes to the one with the lowest index.
- R4: A buffer that passes its filter but is disabled at the decision strobe is skipped, and the next lowest passing enabled buffer takes the frame.
- R5: The enable vector is sampled only at the decision strobe. Changing it during the wait does not change the chosen buffer.
- R6: When no enabled buffer passes, the frame is dropped. No flag, pointer or buffer content changes.
- R7: An error indicated during the wait aborts the frame with no change to flags, pointer or buffers.
- R8: The store happens on the STORE_DLY+1-th rising edge after the edge that samples the decision strobe. It writes id, DLC and data into the chosen buffer, sets its receive flag, loads its remote flag with the frame's RTR bit, and loads the last-event pointer with the buffer index.
- R9: Storing into a buffer whose receive flag is already 1 sets that buffer's overrun flag.
- R10: A 1 on a flag-clear bit clears that buffer's three flags. If the clear and a store to the same buffer fall in one cycle, the clear acts first: the receive flag ends at 1 and the overrun flag at 0.
- R11: Writes to buffer identifiers, mask selects and shared masks take effect only while the halt input is 1, and are otherwise ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_i | input | 1 | Controller halted; enables configuration writes |
| cfg_buf_we | input | 1 | Write strobe for one buffer's identifier and mask select |
| cfg_buf_idx | input | IDX_W | Buffer addressed by the configuration write |
| cfg_buf_id | input | IDW | Identifier to write |
| cfg_buf_msel | input | 2 | Mask select to write (0 exact, 1 mask A, 2 mask B) |
| cfg_mask_we | input | 1 | Write strobe for a shared mask |
| cfg_mask_which | input | 1 | 0 selects mask A, 1 selects mask B |
| cfg_mask_val | input | IDW | Mask value, 1 = don't care |
| buf_en_i | input | NBUF | Per-buffer enable vector |
| flag_clr_i | input | NBUF | Per-buffer flag clear |
| rx_decide_i | input | 1 | Decision strobe from the frame receiver |
| rx_err_i | input | 1 | Error seen before the store; aborts the frame |
| rx_id_i | input | IDW | Received identifier |
| rx_rtr_i | input | 1 | Received remote-request bit |
| rx_dlc_i | input | DLCW | Received length code |
| rx_data_i | input | DATAW | Received payload |
| rd_idx_i | input | IDX_W | Buffer selected for readout |
| rd_id_o | output | IDW | Stored identifier of the selected buffer |
| rd_dlc_o | output | DLCW | Stored length code of the selected buffer |
| rd_data_o | output | DATAW | Stored payload of the selected buffer |
| rcv_flags_o | output | NBUF | Receive-complete flags |
| ovr_flags_o | output | NBUF | Overrun flags |
| rtr_flags_o | output | NBUF | Remote-frame flags |
| last_ptr_o | output | IDX_W | Index of the last buffer written |

## Verification
Two pairs of events can land on the same clock edge. The first is a software flag clear and the store into the same buffer. The bench raises the clear one cycle before the computed store edge, so both take effect on that edge. It then expects the receive flag at 1 and the overrun flag at 0, even though the buffer was already full. The second is an enable being dropped right after the decision strobe, while the frame waits to be stored. Here the frame must still land in the buffer chosen at the strobe and not move elsewhere.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_STORE = 2'd2
    } rx_state_e;

    typedef enum logic [1:0] {
        MSEL_EXACT = 2'd0,
        MSEL_A     = 2'd1,
        MSEL_B     = 2'd2
    } msel_e;

endpackage

// File: rtl/can_rx_filter.sv
module can_rx_filter
    import can_rx_pkg::*;
#(
    parameter int NBUF = 16,
    parameter int IDW  = 29
) (
    input  logic [IDW-1:0]             rx_id,
    input  logic [NBUF-1:0][IDW-1:0]   buf_id,
    input  logic [NBUF-1:0][1:0]       buf_msel,
    input  logic [IDW-1:0]             mask_a,
    input  logic [IDW-1:0]             mask_b,
    output logic [NBUF-1:0]            match
);

    for (genvar g = 0; g < NBUF; g++) begin : g_flt
        logic [IDW-1:0] care;
        always_comb begin
            unique case (msel_e'(buf_msel[g]))
                MSEL_A:  care = ~mask_a;
                MSEL_B:  care = ~mask_b;
                default: care = '1;
            endcase
            match[g] = (((rx_id ^ buf_id[g]) & care) == '0);
        end
    end

endmodule

// File: rtl/can_rx_prio.sv
module can_rx_prio #(
    parameter int NBUF  = 16,
    parameter int IDX_W = $clog2(NBUF)
) (
    input  logic [NBUF-1:0]  req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = NBUF - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/can_rx_bufs.sv
module can_rx_bufs #(
    parameter int NBUF  = 16,
    parameter int IDW   = 29,
    parameter int DLCW  = 4,
    parameter int DATAW = 64,
    parameter int IDX_W = $clog2(NBUF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [IDW-1:0]   wr_id,
    input  logic [DLCW-1:0]  wr_dlc,
    input  logic [DATAW-1:0] wr_data,
    input  logic             wr_rtr,
    input  logic [NBUF-1:0]  flag_clr,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [IDW-1:0]   rd_id,
    output logic [DLCW-1:0]  rd_dlc,
    output logic [DATAW-1:0] rd_data,
    output logic [NBUF-1:0]  rcv_flags,
    output logic [NBUF-1:0]  ovr_flags,
    output logic [NBUF-1:0]  rtr_flags,
    output logic [IDX_W-1:0] last_ptr
);

    logic [IDW-1:0]   id_mem   [NBUF];
    logic [DLCW-1:0]  dlc_mem  [NBUF];
    logic [DATAW-1:0] data_mem [NBUF];

    for (genvar g = 0; g < NBUF; g++) begin : g_buf
        logic hit;
        logic rcv_eff;
        assign hit     = wr_en && (wr_idx == IDX_W'(g));
        assign rcv_eff = rcv_flags[g] && !flag_clr[g];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rcv_flags[g] <= 1'b0;
                ovr_flags[g] <= 1'b0;
                rtr_flags[g] <= 1'b0;
                id_mem[g]    <= '0;
                dlc_mem[g]   <= '0;
                data_mem[g]  <= '0;
            end else if (hit) begin
                rcv_flags[g] <= 1'b1;
                ovr_flags[g] <= rcv_eff || (ovr_flags[g] && !flag_clr[g]);
                rtr_flags[g] <= wr_rtr;
                id_mem[g]    <= wr_id;
                dlc_mem[g]   <= wr_dlc;
                data_mem[g]  <= wr_data;
            end else if (flag_clr[g]) begin
                rcv_flags[g] <= 1'b0;
                ovr_flags[g] <= 1'b0;
                rtr_flags[g] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     last_ptr <= '0;
        else if (wr_en) last_ptr <= wr_idx;
    end

    assign rd_id   = id_mem[rd_idx];
    assign rd_dlc  = dlc_mem[rd_idx];
    assign rd_data = data_mem[rd_idx];

endmodule

// File: rtl/can_rx_alloc.sv
module can_rx_alloc
    import can_rx_pkg::*;
#(
    parameter int NBUF      = 16,
    parameter int IDW       = 29,
    parameter int DLCW      = 4,
    parameter int DATAW     = 64,
    parameter int STORE_DLY = 3,
    parameter int IDX_W     = $clog2(NBUF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_i,
    input  logic             cfg_buf_we,
    input  logic [IDX_W-1:0] cfg_buf_idx,
    input  logic [IDW-1:0]   cfg_buf_id,
    input  logic [1:0]       cfg_buf_msel,
    input  logic             cfg_mask_we,
    input  logic             cfg_mask_which,
    input  logic [IDW-1:0]   cfg_mask_val,
    input  logic [NBUF-1:0]  buf_en_i,
    input  logic [NBUF-1:0]  flag_clr_i,
    input  logic             rx_decide_i,
    input  logic             rx_err_i,
    input  logic [IDW-1:0]   rx_id_i,
    input  logic             rx_rtr_i,
    input  logic [DLCW-1:0]  rx_dlc_i,
    input  logic [DATAW-1:0] rx_data_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [IDW-1:0]   rd_id_o,
    output logic [DLCW-1:0]  rd_dlc_o,
    output logic [DATAW-1:0] rd_data_o,
    output logic [NBUF-1:0]  rcv_flags_o,
    output logic [NBUF-1:0]  ovr_flags_o,
    output logic [NBUF-1:0]  rtr_flags_o,
    output logic [IDX_W-1:0] last_ptr_o
);

    localparam int CNT_W = (STORE_DLY > 1) ? $clog2(STORE_DLY) : 1;

    // configuration held for the filters
    logic [NBUF-1:0][IDW-1:0] buf_id;
    logic [NBUF-1:0][1:0]     buf_msel;
    logic [IDW-1:0]           mask_a;
    logic [IDW-1:0]           mask_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_id   <= '0;
            buf_msel <= '0;
            mask_a   <= '0;
            mask_b   <= '0;
        end else if (halt_i) begin
            if (cfg_buf_we) begin
                buf_id[cfg_buf_idx]   <= cfg_buf_id;
                buf_msel[cfg_buf_idx] <= cfg_buf_msel;
            end
            if (cfg_mask_we) begin
                if (cfg_mask_which) mask_b <= cfg_mask_val;
                else                mask_a <= cfg_mask_val;
            end
        end
    end

    // parallel acceptance filtering
    logic [NBUF-1:0] match;

    can_rx_filter #(.NBUF(NBUF), .IDW(IDW)) u_filter (
        .rx_id    (rx_id_i),
        .buf_id   (buf_id),
        .buf_msel (buf_msel),
        .mask_a   (mask_a),
        .mask_b   (mask_b),
        .match    (match)
    );

    // state machine
    rx_state_e        state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic [NBUF-1:0]  hit_q;
    logic [IDW-1:0]   f_id;
    logic [DLCW-1:0]  f_dlc;
    logic [DATAW-1:0] f_data;
    logic             f_rtr;
    logic             cnt_done;

    assign cnt_done = (cnt == CNT_W'(STORE_DLY - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (rx_decide_i) state_nx = ST_WAIT;
            ST_WAIT: begin
                if (rx_err_i)      state_nx = ST_IDLE;
                else if (cnt_done) state_nx = ST_STORE;
            end
            ST_STORE: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            hit_q  <= '0;
            f_id   <= '0;
            f_dlc  <= '0;
            f_data <= '0;
            f_rtr  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (rx_decide_i) begin
                        hit_q  <= match & buf_en_i;
                        f_id   <= rx_id_i;
                        f_dlc  <= rx_dlc_i;
                        f_data <= rx_data_i;
                        f_rtr  <= rx_rtr_i;
                    end
                end
                ST_WAIT:  cnt <= cnt + CNT_W'(1);
                ST_STORE: cnt <= '0;
                default:  cnt <= '0;
            endcase
        end
    end

    // buffer choice and write
    logic             sel_any;
    logic [IDX_W-1:0] sel_idx;
    logic             wr_en;

    can_rx_prio #(.NBUF(NBUF), .IDX_W(IDX_W)) u_prio (
        .req (hit_q),
        .any (sel_any),
        .idx (sel_idx)
    );

    assign wr_en = (state == ST_STORE) && sel_any;

    can_rx_bufs #(
        .NBUF(NBUF), .IDW(IDW), .DLCW(DLCW), .DATAW(DATAW), .IDX_W(IDX_W)
    ) u_bufs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (sel_idx),
        .wr_id     (f_id),
        .wr_dlc    (f_dlc),
        .wr_data   (f_data),
        .wr_rtr    (f_rtr),
        .flag_clr  (flag_clr_i),
        .rd_idx    (rd_idx_i),
        .rd_id     (rd_id_o),
        .rd_dlc    (rd_dlc_o),
        .rd_data   (rd_data_o),
        .rcv_flags (rcv_flags_o),
        .ovr_flags (ovr_flags_o),
        .rtr_flags (rtr_flags_o),
        .last_ptr  (last_ptr_o)
    );

endmodule

// File: rtl/can_rx_alloc_chk.sv
module can_rx_alloc_chk
    import can_rx_pkg::*;
#(
    parameter int NBUF  = 16,
    parameter int IDW   = 29,
    parameter int IDX_W = $clog2(NBUF)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     halt_i,
    input  logic                     rx_err_i,
    input  logic [NBUF-1:0]          flag_clr_i,
    input  rx_state_e                state,
    input  logic [NBUF-1:0]          hit_q,
    input  logic [IDX_W-1:0]         sel_idx,
    input  logic [NBUF-1:0][IDW-1:0] buf_id,
    input  logic [IDW-1:0]           mask_a,
    input  logic [IDW-1:0]           mask_b,
    input  logic [NBUF-1:0]          rcv_flags_o,
    input  logic [NBUF-1:0]          ovr_flags_o,
    input  logic [IDX_W-1:0]         last_ptr_o
);

    logic [NBUF-1:0] below;
    assign below = (NBUF'(1) << sel_idx) - NBUF'(1);

    p_lowest_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STORE && hit_q != '0) |-> (hit_q[sel_idx] && (hit_q & below) == '0));

    p_enable_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |=> $stable(hit_q));

    p_drop_keeps_ptr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STORE && hit_q == '0) |=> $stable(last_ptr_o));

    p_abort_to_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && rx_err_i) |=> (state == ST_IDLE && $stable(last_ptr_o)));

    p_store_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STORE && hit_q != '0) |=>
            (rcv_flags_o[$past(sel_idx)] && last_ptr_o == $past(sel_idx)));

    p_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STORE && hit_q != '0 && rcv_flags_o[sel_idx] && !flag_clr_i[sel_idx])
            |=> ovr_flags_o[$past(sel_idx)]);

    p_cfg_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !halt_i |=> ($stable(buf_id) && $stable(mask_a) && $stable(mask_b)));

endmodule

bind can_rx_alloc can_rx_alloc_chk #(.NBUF(NBUF), .IDW(IDW), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .halt_i      (halt_i),
    .rx_err_i    (rx_err_i),
    .flag_clr_i  (flag_clr_i),
    .state       (state),
    .hit_q       (hit_q),
    .sel_idx     (sel_idx),
    .buf_id      (buf_id),
    .mask_a      (mask_a),
    .mask_b      (mask_b),
    .rcv_flags_o (rcv_flags_o),
    .ovr_flags_o (ovr_flags_o),
    .last_ptr_o  (last_ptr_o)
);

// File: tb/sim_can_rx_alloc.sv
`timescale 1ns/1ps
module sim_can_rx_alloc;

    localparam int NBUF  = 16;
    localparam int IDW   = 29;
    localparam int DLCW  = 4;
    localparam int DATAW = 64;
    localparam int SDLY  = 3;
    localparam int IDX_W = $clog2(NBUF);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             halt_i = 1'b0;
    logic             cfg_buf_we = 1'b0;
    logic [IDX_W-1:0] cfg_buf_idx = '0;
    logic [IDW-1:0]   cfg_buf_id = '0;
    logic [1:0]       cfg_buf_msel = '0;
    logic             cfg_mask_we = 1'b0;
    logic             cfg_mask_which = 1'b0;
    logic [IDW-1:0]   cfg_mask_val = '0;
    logic [NBUF-1:0]  buf_en_i = '0;
    logic [NBUF-1:0]  flag_clr_i = '0;
    logic             rx_decide_i = 1'b0;
    logic             rx_err_i = 1'b0;
    logic [IDW-1:0]   rx_id_i = '0;
    logic             rx_rtr_i = 1'b0;
    logic [DLCW-1:0]  rx_dlc_i = '0;
    logic [DATAW-1:0] rx_data_i = '0;
    logic [IDX_W-1:0] rd_idx_i = '0;
    logic [IDW-1:0]   rd_id_o;
    logic [DLCW-1:0]  rd_dlc_o;
    logic [DATAW-1:0] rd_data_o;
    logic [NBUF-1:0]  rcv_flags_o, ovr_flags_o, rtr_flags_o;
    logic [IDX_W-1:0] last_ptr_o;

    always #5 clk = ~clk;

    can_rx_alloc #(.NBUF(NBUF), .IDW(IDW), .DLCW(DLCW), .DATAW(DATAW), .STORE_DLY(SDLY)) u0 (
        .clk(clk), .rst_n(rst_n), .halt_i(halt_i),
        .cfg_buf_we(cfg_buf_we), .cfg_buf_idx(cfg_buf_idx), .cfg_buf_id(cfg_buf_id),
        .cfg_buf_msel(cfg_buf_msel), .cfg_mask_we(cfg_mask_we), .cfg_mask_which(cfg_mask_which),
        .cfg_mask_val(cfg_mask_val), .buf_en_i(buf_en_i), .flag_clr_i(flag_clr_i),
        .rx_decide_i(rx_decide_i), .rx_err_i(rx_err_i), .rx_id_i(rx_id_i),
        .rx_rtr_i(rx_rtr_i), .rx_dlc_i(rx_dlc_i), .rx_data_i(rx_data_i),
        .rd_idx_i(rd_idx_i), .rd_id_o(rd_id_o), .rd_dlc_o(rd_dlc_o), .rd_data_o(rd_data_o),
        .rcv_flags_o(rcv_flags_o), .ovr_flags_o(ovr_flags_o), .rtr_flags_o(rtr_flags_o),
        .last_ptr_o(last_ptr_o)
    );

    typedef struct {
        string            tag;
        int               idx;
        logic [IDW-1:0]   id;
        logic [DLCW-1:0]  dlc;
        logic [DATAW-1:0] data;
        logic [NBUF-1:0]  rcv;
        logic [NBUF-1:0]  ovr;
        logic [NBUF-1:0]  rtr;
        logic [IDX_W-1:0] ptr;
    } exp_t;

    exp_t exp_q[$];
    int n_chk = 0;
    int n_fail = 0;
    logic [NBUF-1:0]  m_rcv = '0, m_ovr = '0, m_rtr = '0;
    logic [IDX_W-1:0] m_ptr = '0;
    logic [IDW-1:0]   m_id  [NBUF];
    logic [DLCW-1:0]  m_dlc [NBUF];
    logic [DATAW-1:0] m_dat [NBUF];

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic push_state(input string tag, input int idx);
        exp_t e;
        e.tag = tag; e.idx = idx;
        e.rcv = m_rcv; e.ovr = m_ovr; e.rtr = m_rtr; e.ptr = m_ptr;
        if (idx >= 0) begin
            e.id = m_id[idx]; e.dlc = m_dlc[idx]; e.data = m_dat[idx];
        end else begin
            e.id = '0; e.dlc = '0; e.data = '0;
        end
        exp_q.push_back(e);
        wait (exp_q.size() == 0);
        @(negedge clk);
    endtask

    // monitor: pops expected items and compares at the ports
    initial begin
        forever begin
            wait (exp_q.size() > 0);
            begin
                exp_t e;
                e = exp_q[0];
                check(rcv_flags_o == e.rcv, {e.tag, " rcv flags"}, 64'(rcv_flags_o), 64'(e.rcv));
                check(ovr_flags_o == e.ovr, {e.tag, " ovr flags"}, 64'(ovr_flags_o), 64'(e.ovr));
                check(rtr_flags_o == e.rtr, {e.tag, " rtr flags"}, 64'(rtr_flags_o), 64'(e.rtr));
                check(last_ptr_o == e.ptr, {e.tag, " last ptr"}, 64'(last_ptr_o), 64'(e.ptr));
                if (e.idx >= 0) begin
                    rd_idx_i = IDX_W'(e.idx);
                    #1;
                    check(rd_id_o == e.id, {e.tag, " stored id"}, 64'(rd_id_o), 64'(e.id));
                    check(rd_dlc_o == e.dlc, {e.tag, " stored dlc"}, 64'(rd_dlc_o), 64'(e.dlc));
                    check(rd_data_o == e.data, {e.tag, " stored data"}, rd_data_o, e.data);
                end
                void'(exp_q.pop_front());
            end
        end
    end

    task automatic cfg_buf(input int idx, input logic [IDW-1:0] id, input logic [1:0] ms);
        @(negedge clk);
        cfg_buf_we = 1'b1; cfg_buf_idx = IDX_W'(idx); cfg_buf_id = id; cfg_buf_msel = ms;
        @(negedge clk);
        cfg_buf_we = 1'b0;
    endtask

    task automatic cfg_mask(input bit which, input logic [IDW-1:0] val);
        @(negedge clk);
        cfg_mask_we = 1'b1; cfg_mask_which = which; cfg_mask_val = val;
        @(negedge clk);
        cfg_mask_we = 1'b0;
    endtask

    // driver: one frame through decision, wait and store
    task automatic send(input string tag, input logic [IDW-1:0] id, input bit rtr,
                        input logic [DATAW-1:0] data, input logic [DLCW-1:0] dlc,
                        input int exp_idx, input bit err, input bit clr_same, input int drop_en);
        @(negedge clk);
        rx_id_i = id; rx_rtr_i = rtr; rx_data_i = data; rx_dlc_i = dlc; rx_decide_i = 1'b1;
        @(negedge clk);
        rx_decide_i = 1'b0;
        if (drop_en >= 0) buf_en_i[drop_en] = 1'b0;
        if (err) rx_err_i = 1'b1;
        @(negedge clk);
        rx_err_i = 1'b0;
        repeat (SDLY - 1) @(negedge clk);
        if (clr_same && exp_idx >= 0) flag_clr_i[exp_idx] = 1'b1;
        @(negedge clk);
        flag_clr_i = '0;
        if (exp_idx >= 0 && !err) begin
            if (clr_same) begin
                m_ovr[exp_idx] = 1'b0;
            end else begin
                m_ovr[exp_idx] = m_ovr[exp_idx] | m_rcv[exp_idx];
            end
            m_rcv[exp_idx] = 1'b1;
            m_rtr[exp_idx] = rtr;
            m_ptr = IDX_W'(exp_idx);
            m_id[exp_idx] = id; m_dlc[exp_idx] = dlc; m_dat[exp_idx] = data;
            push_state(tag, exp_idx);
        end else begin
            push_state(tag, -1);
        end
    endtask

    task automatic clear(input string tag, input int idx);
        @(negedge clk);
        flag_clr_i[idx] = 1'b1;
        @(negedge clk);
        flag_clr_i = '0;
        m_rcv[idx] = 1'b0; m_ovr[idx] = 1'b0; m_rtr[idx] = 1'b0;
        push_state(tag, -1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung run, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NBUF; i++) begin
            m_id[i] = '0; m_dlc[i] = '0; m_dat[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        push_state("R1 reset", -1);

        // configuration while halted: buffer i id 0x100+i, buffer 5 via mask A, 6 via mask B
        halt_i = 1'b1;
        for (int i = 0; i < NBUF; i++) cfg_buf(i, IDW'(32'h100 + i), 2'd0);
        cfg_buf(5, IDW'(32'h105), 2'd1);
        cfg_buf(6, IDW'(32'h106), 2'd2);
        cfg_mask(1'b0, IDW'(32'h00F));
        cfg_mask(1'b1, IDW'(32'h0F0));
        halt_i = 1'b0;
        // R11: writes while running must be ignored
        cfg_buf(3, IDW'(32'h7FF), 2'd0);
        cfg_mask(1'b0, '0);
        buf_en_i = '1;

        send("R8 exact store", IDW'(32'h102), 1'b0, 64'h1122334455667788, 4'd8, 2, 0, 0, -1);
        send("R2 R3 mask A lowest index", IDW'(32'h10A), 1'b0, 64'hA5A5, 4'd2, 5, 0, 0, -1);
        buf_en_i[5] = 1'b0;
        send("R4 disabled skipped", IDW'(32'h10A), 1'b0, 64'hBEEF, 4'd3, 10, 0, 0, -1);
        buf_en_i[5] = 1'b1;
        send("R2 mask B remote", IDW'(32'h1F6), 1'b1, 64'h0, 4'd0, 6, 0, 0, -1);
        send("R9 overrun", IDW'(32'h102), 1'b0, 64'hCAFE, 4'd4, 2, 0, 0, -1);
        send("R5 enable dropped in wait", IDW'(32'h103), 1'b0, 64'h3333, 4'd1, 3, 0, 0, 3);
        buf_en_i[3] = 1'b1;
        send("R6 R11 no candidate", IDW'(32'h7FF), 1'b0, 64'hDEAD, 4'd5, -1, 0, 0, -1);
        send("R7 error abort", IDW'(32'h104), 1'b0, 64'h4444, 4'd6, 4, 1, 0, -1);
        send("R8 buffer 4", IDW'(32'h104), 1'b0, 64'h5555, 4'd7, 4, 0, 0, -1);
        send("R10 clear with store", IDW'(32'h104), 1'b1, 64'h6666, 4'd8, 4, 0, 1, -1);
        clear("R10 clear only", 2);
        send("R11 mask A unchanged", IDW'(32'h10C), 1'b0, 64'h7777, 4'd1, 5, 0, 0, -1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule